// File: doc/BRIEF.md
# Video-Memory Slot Arbiter with Write Queue

This block decides who uses each video-memory access slot. A slot opens on every fourth serial-clock tick. When a slot opens, an input tells whether the display pipeline has reserved it. If the slot is free, the block gives it to a four-entry queue of pending CPU writes. Only when that queue is empty does it give the slot to a one-word read-ahead latch. The CPU side has three operations. An address setup loads the target memory, the start address, the per-access step and the direction. A data write is pushed into the queue. A data read takes the word held in the latch. A single stall output tells the CPU to keep its request asserted until the block can accept it.

The memory side has two kinds of target. The large video RAM is byte-wide, so one CPU word costs two slots: the even (low) byte first, then the odd (high) byte. The colour RAM and the scroll RAM are word-wide, so one word costs one slot. Each queue entry keeps its own target, address, data and a byte-phase flag. Writes therefore drain correctly even after the CPU has moved to a new address.

Three state machines make up the block. The slot grant takes one of four values each cycle: GR_IDLE (no slot, or nothing to do), GR_DISP (the display owns the slot), GR_FIFO (the oldest queue entry goes out) and GR_PREF (the latch is filled). The read-ahead latch moves through PF_OFF, PF_WANT, PF_LOW and PF_FULL. A read setup, a data access in read mode, or a read request while in PF_OFF moves it to PF_WANT. A write setup moves it to PF_OFF. A granted slot moves PF_WANT to PF_LOW (video RAM) or to PF_FULL (word RAMs), and moves PF_LOW to PF_FULL. The port mode is MODE_WRITE or MODE_READ and is loaded at each setup.

Top module: `vslot_arbiter`

## Requirements
- R1: While reset is asserted and just after it is released, stall is low, mem_en is low, the queue is empty and the latch is in PF_OFF.
- R2: A memory access (mem_en high) happens only in the cycle of the 4th, 8th, 12th, ... sc_tick counted from reset release.
- R3: No memory access happens in a slot where disp_own is high.
- R4: Queued writes leave in arrival order. The target codes are 0 for video RAM, 1 for colour RAM and 2 for scroll RAM. A video RAM word takes two slots. The first slot writes data[7:0] to the address with bit 0 cleared. The second slot writes data[15:8] to the address with bit 0 set. In both slots the byte is on mem_wdata[7:0] and mem_wdata[15:8] is zero.
- R5: A write to colour RAM or scroll RAM takes one slot. It carries the full word at the unmodified address.
- R6: The queue holds 4 entries. While it is full, a write request raises stall. The request is accepted only after at least one entry has fully drained, which for video RAM means both of its bytes.
- R7: No read access (mem_en high, mem_we low) happens while the queue holds an entry.
- R8: A setup with cfg_read=1 starts a read-ahead at once, with no rd_req needed. It uses two read slots for video RAM (even byte into the low half, then odd byte into the high half) and one read slot for the word RAMs.
- R9: A read request stalls until the latch holds the word for the current address. The cycle that accepts it presents that word on rd_data.
- R10: After each accepted write or read, the address advances by the cfg_inc value loaded at setup, modulo 2^16.
- R11: After a read is accepted, the latch refills from the advanced address, so back-to-back reads return consecutive words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_tick | input | 1 | Serial-clock tick enable |
| disp_own | input | 1 | Display pipeline owns the current slot |
| cfg_we | input | 1 | Address setup strobe |
| cfg_read | input | 1 | Setup direction: 1 read, 0 write |
| cfg_tgt | input | 2 | Setup target code (0 video RAM, 1 colour, 2 scroll) |
| cfg_addr | input | 16 | Setup start address |
| cfg_inc | input | 8 | Address step per access |
| wr_req | input | 1 | CPU data write request, held until not stalled |
| wr_data | input | 16 | CPU write word |
| rd_req | input | 1 | CPU data read request, held until not stalled |
| rd_data | output | 16 | Read-ahead latch contents |
| stall | output | 1 | CPU must hold its request |
| mem_en | output | 1 | Memory access in this cycle |
| mem_we | output | 1 | Access is a write |
| mem_tgt | output | 2 | Memory target code |
| mem_addr | output | 16 | Memory byte or word address |
| mem_wdata | output | 16 | Write data (byte in bits 7:0 for video RAM) |
| mem_rdata | input | 16 | Read data returned in the same cycle |

## Verification
The hardest case to reach is a full queue with a fifth write waiting, followed by a discharge that needs two video-RAM byte slots before the stall may lift. The bench holds disp_own high to block every slot and fills the queue. It then keeps a fifth request waiting for a fixed interval and releases the display. It counts the write accesses seen between the release and the acceptance. A second hard case is a read setup issued while writes are still queued. The bench queues writes behind a blocked display, issues the read setup, and releases the display. It then confirms that every write access comes before the first read access and that the read stalls until the latch is filled. A random display-ownership pattern then runs through a longer sequence of writes.

// File: rtl/vsa_pkg.sv
package vsa_pkg;

    localparam int AW = 16;
    localparam int DW = 16;

    typedef enum logic [1:0] {
        TGT_VRAM  = 2'd0,
        TGT_CRAM  = 2'd1,
        TGT_VSRAM = 2'd2,
        TGT_RSVD  = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        GR_IDLE = 2'd0,
        GR_DISP = 2'd1,
        GR_FIFO = 2'd2,
        GR_PREF = 2'd3
    } grant_e;

    typedef enum logic [1:0] {
        PF_OFF  = 2'd0,
        PF_WANT = 2'd1,
        PF_LOW  = 2'd2,
        PF_FULL = 2'd3
    } pf_e;

    typedef enum logic {
        MODE_WRITE = 1'b0,
        MODE_READ  = 1'b1
    } mode_e;

    typedef struct packed {
        tgt_e          tgt;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          hi;
    } wentry_t;

endpackage

// File: rtl/vsa_slot_timer.sv
module vsa_slot_timer #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sc_tick,
    output logic slot
);
    localparam int          CW   = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sc_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign slot = sc_tick && (cnt_q == LAST);

endmodule

// File: rtl/vsa_wfifo.sv
module vsa_wfifo
    import vsa_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  wentry_t push_ent,
    input  logic    advance,
    output wentry_t head,
    output logic    empty,
    output logic    full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = PW + 1;
    localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    wentry_t       ent_q [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] cnt_q;
    logic          head_split, pop;

    // A video RAM entry whose low byte has not gone out stays at the head.
    assign head_split = (head.tgt == TGT_VRAM) && !head.hi;
    assign pop        = advance && !head_split;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_q[i] <= '0;
                end else if (push && !full && wr_ptr_q == PW'(i)) begin
                    ent_q[i] <= push_ent;
                end else if (advance && head_split && rd_ptr_q == PW'(i)) begin
                    ent_q[i].hi <= 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push && !full) begin
                wr_ptr_q <= (wr_ptr_q == LASTP) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop) begin
                rd_ptr_q <= (rd_ptr_q == LASTP) ? '0 : rd_ptr_q + 1'b1;
            end
            unique case ({push && !full, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = ent_q[rd_ptr_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == FULLC);

endmodule

// File: rtl/vsa_prefetch.sv
module vsa_prefetch
    import vsa_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stop,
    input  logic          restart,
    input  logic          grant,
    input  logic          is_vram,
    input  logic [DW-1:0] rdata,
    output logic          want,
    output logic          hi_phase,
    output logic          full,
    output logic [DW-1:0] word
);
    pf_e           state_q, state_d;
    logic [DW-1:0] latch_q;

    always_comb begin
        state_d = state_q;
        if (stop) begin
            state_d = PF_OFF;
        end else if (restart) begin
            state_d = PF_WANT;
        end else if (grant) begin
            unique case (state_q)
                PF_WANT: state_d = is_vram ? PF_LOW : PF_FULL;
                PF_LOW:  state_d = PF_FULL;
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PF_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (grant && !stop && !restart) begin
            unique case (state_q)
                PF_WANT: begin
                    if (is_vram) latch_q[7:0] <= rdata[7:0];
                    else         latch_q      <= rdata;
                end
                PF_LOW:  latch_q[DW-1:8] <= rdata[7:0];
                default: latch_q <= latch_q;
            endcase
        end
    end

    always_comb begin
        want     = (state_q == PF_WANT) || (state_q == PF_LOW);
        hi_phase = (state_q == PF_LOW);
        full     = (state_q == PF_FULL);
        word     = latch_q;
    end

endmodule

// File: rtl/vslot_arbiter.sv
module vslot_arbiter
    import vsa_pkg::*;
#(
    parameter int FIFO_DEPTH     = 4,
    parameter int TICKS_PER_SLOT = 4,
    parameter int INC_W          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sc_tick,
    input  logic          disp_own,
    input  logic          cfg_we,
    input  logic          cfg_read,
    input  logic [1:0]    cfg_tgt,
    input  logic [15:0]   cfg_addr,
    input  logic [INC_W-1:0] cfg_inc,
    input  logic          wr_req,
    input  logic [15:0]   wr_data,
    input  logic          rd_req,
    output logic [15:0]   rd_data,
    output logic          stall,
    output logic          mem_en,
    output logic          mem_we,
    output logic [1:0]    mem_tgt,
    output logic [15:0]   mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata
);
    localparam int PAD_W = AW - INC_W;

    // CPU-side port state
    logic [AW-1:0]    addr_q;
    tgt_e             tgt_q;
    mode_e            mode_q;
    logic [INC_W-1:0] inc_q;

    logic    slot_now;
    grant_e  grant;
    wentry_t head, push_ent;
    logic    fifo_empty, fifo_full;
    logic    pf_want, pf_hi, pf_full, pf_stop, pf_restart;
    logic    wr_acc, rd_acc;
    logic    head_vram, pf_vram;

    vsa_slot_timer #(.TICKS(TICKS_PER_SLOT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sc_tick (sc_tick),
        .slot    (slot_now)
    );

    // Handshake at the CPU port
    assign wr_acc = wr_req && !fifo_full;
    assign rd_acc = rd_req && !wr_req && pf_full;
    assign stall  = (wr_req && fifo_full) || (rd_req && !wr_req && !pf_full);

    always_comb begin
        push_ent      = '0;
        push_ent.tgt  = tgt_q;
        push_ent.addr = addr_q;
        push_ent.data = wr_data;
        push_ent.hi   = 1'b0;
    end

    vsa_wfifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_acc),
        .push_ent (push_ent),
        .advance  (grant == GR_FIFO),
        .head     (head),
        .empty    (fifo_empty),
        .full     (fifo_full)
    );

    assign pf_stop    = cfg_we && !cfg_read;
    assign pf_restart = (cfg_we && cfg_read)
                     || (!cfg_we && mode_q == MODE_READ && (wr_acc || rd_acc))
                     || (!cfg_we && rd_acc)
                     || (!cfg_we && rd_req && !wr_req && !pf_want && !pf_full);
    assign pf_vram    = (tgt_q == TGT_VRAM);

    vsa_prefetch u_pf (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop     (pf_stop),
        .restart  (pf_restart),
        .grant    (grant == GR_PREF),
        .is_vram  (pf_vram),
        .rdata    (mem_rdata),
        .want     (pf_want),
        .hi_phase (pf_hi),
        .full     (pf_full),
        .word     (rd_data)
    );

    // Port register: setup loads everything, data accesses step the address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            tgt_q  <= TGT_VRAM;
            mode_q <= MODE_WRITE;
            inc_q  <= '0;
        end else if (cfg_we) begin
            addr_q <= cfg_addr;
            tgt_q  <= tgt_e'(cfg_tgt);
            mode_q <= cfg_read ? MODE_READ : MODE_WRITE;
            inc_q  <= cfg_inc;
        end else if (wr_acc || rd_acc) begin
            addr_q <= addr_q + {{PAD_W{1'b0}}, inc_q};
        end
    end

    // Slot grant decision: display, then queue, then read-ahead
    always_comb begin
        if (!slot_now)        grant = GR_IDLE;
        else if (disp_own)    grant = GR_DISP;
        else if (!fifo_empty) grant = GR_FIFO;
        else if (pf_want)     grant = GR_PREF;
        else                  grant = GR_IDLE;
    end

    assign head_vram = (head.tgt == TGT_VRAM);

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_tgt   = TGT_VRAM;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (grant)
            GR_FIFO: begin
                mem_en  = 1'b1;
                mem_we  = 1'b1;
                mem_tgt = head.tgt;
                if (head_vram) begin
                    mem_addr  = {head.addr[AW-1:1], head.hi};
                    mem_wdata = {8'h00, head.hi ? head.data[DW-1:8] : head.data[7:0]};
                end else begin
                    mem_addr  = head.addr;
                    mem_wdata = head.data;
                end
            end
            GR_PREF: begin
                mem_en   = 1'b1;
                mem_tgt  = tgt_q;
                mem_addr = pf_vram ? {addr_q[AW-1:1], pf_hi} : addr_q;
            end
            GR_DISP, GR_IDLE: begin
                mem_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vsa_props.sv
module vsa_props (
    input logic        clk,
    input logic        rst_n,
    input logic        slot_now,
    input logic        disp_own,
    input logic        cfg_we,
    input logic        wr_req,
    input logic        rd_req,
    input logic        stall,
    input logic        mem_en,
    input logic        mem_we,
    input logic [1:0]  mem_tgt,
    input logic [15:0] mem_addr,
    input logic        fifo_empty,
    input logic        fifo_full,
    input logic        pf_full
);
    logic hi_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_pend <= 1'b0;
        end else if (mem_en && mem_we && mem_tgt == 2'd0) begin
            hi_pend <= !mem_addr[0];
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> (!mem_en && !stall));

    a_r2_access_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> slot_now);

    a_r3_display_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !disp_own);

    a_r4_byte_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && mem_tgt == 2'd0) |-> (mem_addr[0] == hi_pend));

    a_r4_high_byte_next: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && hi_pend) |-> (mem_tgt == 2'd0));

    a_r6_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && fifo_full) |-> stall);

    a_r7_queue_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |-> fifo_empty);

    a_r11_latch_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !wr_req && !stall && !cfg_we) |=> !pf_full);

    a_r9_stall_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req && !rd_req) |-> !stall);

endmodule

bind vslot_arbiter vsa_props u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_now   (slot_now),
    .disp_own   (disp_own),
    .cfg_we     (cfg_we),
    .wr_req     (wr_req),
    .rd_req     (rd_req),
    .stall      (stall),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_tgt    (mem_tgt),
    .mem_addr   (mem_addr),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .pf_full    (pf_full)
);

// File: tb/tb_vslot_arbiter.sv
module tb_vslot_arbiter;

    typedef struct {
        logic [1:0]  t;
        logic [15:0] a;
        logic [15:0] d;
    } acc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sc_tick = 1'b0;
    logic        disp_own = 1'b0;
    logic        cfg_we = 1'b0, cfg_read = 1'b0;
    logic [1:0]  cfg_tgt = 2'd0;
    logic [15:0] cfg_addr = '0;
    logic [7:0]  cfg_inc = '0;
    logic        wr_req = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic [15:0] rd_data;
    logic        stall, mem_en, mem_we;
    logic [1:0]  mem_tgt;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    vslot_arbiter dut (
        .clk(clk), .rst_n(rst_n), .sc_tick(sc_tick), .disp_own(disp_own),
        .cfg_we(cfg_we), .cfg_read(cfg_read), .cfg_tgt(cfg_tgt),
        .cfg_addr(cfg_addr), .cfg_inc(cfg_inc),
        .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .stall(stall), .mem_en(mem_en), .mem_we(mem_we), .mem_tgt(mem_tgt),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #10 clk = ~clk;

    // Memory model: byte-wide video RAM, word-wide colour and scroll RAMs
    logic [7:0]  vram  [256];
    logic [15:0] cram  [256];
    logic [15:0] vsram [256];

    always @(posedge clk) begin
        if (mem_en && mem_we) begin
            case (mem_tgt)
                2'd0:    vram[mem_addr[7:0]]  <= mem_wdata[7:0];
                2'd1:    cram[mem_addr[7:0]]  <= mem_wdata;
                default: vsram[mem_addr[7:0]] <= mem_wdata;
            endcase
        end
    end

    always_comb begin
        case (mem_tgt)
            2'd0:    mem_rdata = {8'h00, vram[mem_addr[7:0]]};
            2'd1:    mem_rdata = cram[mem_addr[7:0]];
            default: mem_rdata = vsram[mem_addr[7:0]];
        endcase
    end

    int   checks = 0, errors = 0;
    bit   done = 1'b0;
    acc_t expq[$];
    int   wr_cnt = 0, rd_cnt = 0, tcnt = 0;
    bit   rand_on = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    logic [15:0] b_addr = '0;
    logic [7:0]  b_inc  = '0;
    logic [1:0]  b_tgt  = '0;
    int last_stalls = 0, acc_wr_at = 0, rd_base = 0, wbase = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Serial-clock ticks every other cycle; optional random display ownership
    always @(negedge clk) begin
        sc_tick = ~sc_tick;
        if (rand_on) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            disp_own = lfsr[0] & lfsr[2];
        end
    end

    // Monitor: compares every memory access with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #7;
            if (rst_n) begin
                bit is_slot;
                is_slot = 1'b0;
                if (sc_tick) begin
                    is_slot = (tcnt % 4 == 3);
                    tcnt++;
                end
                if (mem_en) begin
                    chk(is_slot, "R2", "access off slot", 40'(tcnt), 40'(tcnt));
                    chk(!disp_own, "R3", "access in display slot", 40'(disp_own), 40'd0);
                    if (mem_we) begin
                        wr_cnt++;
                        if (expq.size() == 0) begin
                            chk(1'b0, "R4", "unexpected write", {6'd0, mem_tgt, mem_addr, mem_wdata}, 40'd0);
                        end else begin
                            acc_t e;
                            e = expq.pop_front();
                            chk(mem_tgt == e.t && mem_addr == e.a && mem_wdata == e.d,
                                (e.t == 2'd0) ? "R4" : "R5", "write access",
                                {6'd0, mem_tgt, mem_addr, mem_wdata}, {6'd0, e.t, e.a, e.d});
                        end
                    end else begin
                        rd_cnt++;
                        chk(expq.size() == 0, "R7", "read while queue busy",
                            40'(expq.size()), 40'd0);
                    end
                end
            end
        end
    end

    task automatic do_cfg(input bit rd, input logic [1:0] t, input logic [15:0] a, input logic [7:0] inc);
        cfg_we = 1'b1; cfg_read = rd; cfg_tgt = t; cfg_addr = a; cfg_inc = inc;
        b_addr = a; b_inc = inc; b_tgt = t;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_wr(input logic [15:0] d);
        int n;
        n = 0;
        wr_req = 1'b1; wr_data = d;
        #5;
        while (stall) begin
            n++;
            @(negedge clk);
            #5;
        end
        acc_wr_at = wr_cnt;
        if (b_tgt == 2'd0) begin
            expq.push_back('{t: 2'd0, a: {b_addr[15:1], 1'b0}, d: {8'h00, d[7:0]}});
            expq.push_back('{t: 2'd0, a: {b_addr[15:1], 1'b1}, d: {8'h00, d[15:8]}});
        end else begin
            expq.push_back('{t: b_tgt, a: b_addr, d: d});
        end
        b_addr = b_addr + {8'h00, b_inc};
        last_stalls = n;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] exp, input string req);
        int n;
        n = 0;
        rd_req = 1'b1;
        #5;
        while (stall) begin
            n++;
            @(negedge clk);
            #5;
        end
        chk(rd_data == exp, req, "read word", 40'(rd_data), 40'(exp));
        last_stalls = n;
        b_addr = b_addr + {8'h00, b_inc};
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (16) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        #5;
        chk(!stall && !mem_en, "R1", "outputs in reset", {38'd0, stall, mem_en}, 40'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk(!stall && !mem_en, "R1", "outputs after reset", {38'd0, stall, mem_en}, 40'd0);
        @(negedge clk);

        // R4: video RAM words, two byte slots each, low byte first
        do_cfg(1'b0, 2'd0, 16'h0010, 8'd2);
        do_wr(16'hA1B2);
        do_wr(16'hC3D4);
        drain();
        // R5: colour RAM words, one slot each
        do_cfg(1'b0, 2'd1, 16'h0020, 8'd2);
        do_wr(16'h0123);
        do_wr(16'h0456);
        // R10: scroll RAM with a step of 4
        do_cfg(1'b0, 2'd2, 16'h0040, 8'd4);
        do_wr(16'h0AAA);
        do_wr(16'h0BBB);
        drain();

        // R6: fill the queue with every slot blocked, then a fifth write
        disp_own = 1'b1;
        do_cfg(1'b0, 2'd0, 16'h0050, 8'd2);
        for (int i = 0; i < 4; i++) begin
            do_wr(16'h5150 + 16'(i));
            chk(last_stalls == 0, "R6", "write within capacity stalled", 40'(last_stalls), 40'd0);
        end
        fork
            do_wr(16'h5555);
            begin
                repeat (20) @(negedge clk);
                #5;
                chk(stall, "R6", "fifth write not stalled", 40'(stall), 40'd1);
                wbase = wr_cnt;
                @(negedge clk);
                disp_own = 1'b0;
            end
        join
        chk(last_stalls >= 20, "R6", "stall length", 40'(last_stalls), 40'd20);
        chk(acc_wr_at - wbase >= 2, "R6", "accepted before entry drained",
            40'(acc_wr_at - wbase), 40'd2);
        drain();

        // R7, R8, R9: read setup with writes still queued
        disp_own = 1'b1;
        do_cfg(1'b0, 2'd0, 16'h0060, 8'd2);
        do_wr(16'h1111);
        do_wr(16'h2222);
        do_cfg(1'b1, 2'd0, 16'h0010, 8'd2);
        rd_base = rd_cnt;
        disp_own = 1'b0;
        do_rd(16'hA1B2, "R9");
        chk(last_stalls > 0, "R9", "read did not wait for latch", 40'(last_stalls), 40'd1);
        chk(rd_cnt - rd_base == 2, "R8", "video RAM read slots", 40'(rd_cnt - rd_base), 40'd2);
        do_rd(16'hC3D4, "R11");

        // R8 one-slot reads from colour RAM, R11 refill
        do_cfg(1'b1, 2'd1, 16'h0020, 8'd2);
        rd_base = rd_cnt;
        repeat (24) @(negedge clk);
        chk(rd_cnt - rd_base == 1, "R8", "colour read slots without request",
            40'(rd_cnt - rd_base), 40'd1);
        do_rd(16'h0123, "R8");
        chk(last_stalls == 0, "R9", "read stalled with latch full", 40'(last_stalls), 40'd0);
        do_rd(16'h0456, "R11");

        // R10: step of 4 on scroll RAM reads
        do_cfg(1'b1, 2'd2, 16'h0040, 8'd4);
        do_rd(16'h0AAA, "R10");
        do_rd(16'h0BBB, "R10");

        // R3, R4, R5 under a random display-ownership pattern
        do_cfg(1'b0, 2'd0, 16'h0080, 8'd2);
        rand_on = 1'b1;
        for (int i = 0; i < 6; i++) do_wr(16'h8000 + 16'(i * 16'h0111));
        do_cfg(1'b0, 2'd1, 16'h0090, 8'd2);
        for (int i = 0; i < 4; i++) do_wr(16'h0900 + 16'(i));
        drain();
        rand_on = 1'b0;
        disp_own = 1'b0;
        @(negedge clk);
        do_cfg(1'b1, 2'd0, 16'h0082, 8'd2);
        do_rd(16'h8111, "R4");
        do_cfg(1'b1, 2'd1, 16'h0094, 8'd2);
        do_rd(16'h0902, "R5");

        repeat (10) @(negedge clk);
        finish_sim();
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 40'd0, 40'd1);
        finish_sim();
    end

endmodule